// File: doc/BRIEF.md
# Paged Wait-State External Memory Interface

This block lets an 8-bit processor core reach external SRAM or memory-mapped peripherals over a multiplexed pin bus. The core presents an address, write data and a read or write request. It is held by a stall output until the external access finishes, and then it picks up read data. On the pin side, one 8-bit port carries the low address byte and then the data. A second port carries the high address byte. An address-latch pulse marks when the low byte is valid, and active-low read and write strobes frame the data phase.

Two small control registers hold an enable bit, a 3-bit page limit and two 2-bit wait codes. The page limit splits the external space into a lower page and an upper page at a programmable boundary. Each access takes its wait code from the page its address falls in. While the enable bit is clear, the interface is idle and every pin follows the general-purpose output values and directions supplied by the surrounding port logic.

Top module: `xmem_bridge`

## Requirements
- R1: All control bits reset to zero. Register select 0 reads back bit 0 = enable and bit 1 = upper-page wait code bit 1. Register select 1 reads back bits 2:0 = page limit, bits 4:3 = lower-page wait code and bit 5 = upper-page wait code bit 0. Every other bit reads as zero.
- R2: While enable is clear, every pad output and pad output-enable equals its general-purpose counterpart. Core requests are ignored: stall stays low and no strobe occurs.
- R3: While enable is set, the interface owns the pins regardless of the general-purpose directions. The high-address output-enables are all ones. The control pins are all enabled, with bit 0 = address latch (active high), bit 1 = read strobe (active low) and bit 2 = write strobe (active low). Both strobes are high and the latch is low when no access is in progress.
- R4: The cycle after a request is first seen, the latch is high, the low address byte is driven on the shared bus with all output-enables set, and the high byte is on the high port. In the following cycle the latch is low and no strobe is active. The strobe starts in the cycle after that.
- R5: A page limit of 0 makes every address use the upper-page code. A limit n from 1 to 7 places the boundary at EXT_BASE + n × ((2^ADDR_W − EXT_BASE) / 8). Addresses below the boundary use the lower-page code, and addresses at or above it use the upper-page code.
- R6: The strobe stays low for 1 + x cycles, where x is 0, 1, 2 or 2 for codes 0, 1, 2 and 3. Code 3 also adds one recovery cycle after the strobe, with both strobes high and the shared bus released.
- R7: Stall is high from the cycle in which the request is first seen through the last strobe or recovery cycle. It is then low for one completion cycle. This gives 4 + x (+1 for code 3) stalled cycles per access.
- R8: On a write, the shared bus carries the write data with all output-enables set, from the cycle after the latch through the last strobe cycle. The bus is released in every other cycle, including idle cycles.
- R9: On a read, the shared bus is released during the strobe and sampled on the last strobe cycle. The core read data shows that value from the completion cycle on and keeps it through later writes.
- R10: The upper-page code is formed from bit 1 of register 0 (code bit 1) and bit 5 of register 1 (code bit 0). Each half takes effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Control register select (0 or 1) |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Selected control register read value |
| cpu_addr | input | ADDR_W | Core access address |
| cpu_wdata | input | DATA_W | Core write data |
| cpu_rd | input | 1 | Core read request, held while stalled |
| cpu_wr | input | 1 | Core write request, held while stalled |
| cpu_rdata | output | DATA_W | Data from the last completed read |
| cpu_stall | output | 1 | Hold the core; access not yet complete |
| gp_ad_o | input | DATA_W | General-purpose value for the shared bus pins |
| gp_ad_oe | input | DATA_W | General-purpose directions for the shared bus pins |
| gp_ah_o | input | ADDR_W-DATA_W | General-purpose value for the high address pins |
| gp_ah_oe | input | ADDR_W-DATA_W | General-purpose directions for the high address pins |
| gp_ctl_o | input | 3 | General-purpose value for the latch and strobe pins |
| gp_ctl_oe | input | 3 | General-purpose directions for the latch and strobe pins |
| pad_ad_i | input | DATA_W | Shared bus pin input |
| pad_ad_o | output | DATA_W | Shared bus pin output |
| pad_ad_oe | output | DATA_W | Shared bus pin output enables |
| pad_ah_o | output | ADDR_W-DATA_W | High address pin output |
| pad_ah_oe | output | ADDR_W-DATA_W | High address pin output enables |
| pad_ctl_o | output | 3 | Control pin outputs: latch, read strobe, write strobe |
| pad_ctl_oe | output | 3 | Control pin output enables |

## Verification
The bench sweeps all eight page limits against four lower/upper code pairs. In every pair the two codes differ, so the measured strobe length and stall length show which page was chosen. Each configuration is tried at the external base, one address below the boundary, exactly at the boundary and at the top address. This separates the "below" and "at or above" sides of each limit, and shows the limit-0 case sending even the lowest address to the upper page. Every point is run as both a read and a write. This tells apart the driven-data window from the released-bus window and confirms that read data is sampled on the final strobe cycle. Separate patterns cover the disabled state, with arbitrary general-purpose values and a held request, and the enabled idle state, with every general-purpose direction cleared.

// File: rtl/xmem_pkg.sv
// Shared types and wait-code decoding for the external memory interface.
// Assumes a 2-bit wait code; the decode is the single source used by the sequencer.
package xmem_pkg;

    localparam int LIMIT_W = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } xm_state_e;

    // Extra strobe cycles for a wait code.
    function automatic logic [1:0] wait_extra(input logic [CODE_W-1:0] code);
        logic [1:0] r;
        unique case (code)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

    // Whether a wait code adds a trailing recovery cycle.
    function automatic logic wait_recover(input logic [CODE_W-1:0] code);
        return (code == 2'd3);
    endfunction

endpackage

// File: rtl/xmem_ctrl_regs.sv
// Control register pair for the external memory interface.
// Register 0 holds enable and upper-code bit 1; register 1 holds limit,
// lower code and upper-code bit 0. Unused bits are not stored and read zero.
module xmem_ctrl_regs
    import xmem_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                sel,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic                en,
    output logic [LIMIT_W-1:0]  limit,
    output logic [CODE_W-1:0]   code_lo,
    output logic [CODE_W-1:0]   code_hi
);

    logic [1:0] main_q;
    logic [5:0] page_q;

    // Register storage with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
            page_q <= '0;
        end else if (we) begin
            if (sel) page_q <= wdata[5:0];
            else     main_q <= wdata[1:0];
        end
    end

    // Read-back mux, unused bits zero.
    always_comb begin
        rdata = sel ? {2'b00, page_q} : {6'b000000, main_q};
    end

    assign en      = main_q[0];
    assign limit   = page_q[2:0];
    assign code_lo = page_q[4:3];
    assign code_hi = {main_q[1], page_q[5]};

endmodule

// File: rtl/xmem_page_sel.sv
// Page decoder: compares an address against the boundary chosen by the limit
// field and returns the wait code of the page the address falls in.
// Assumes EXT_BASE is below 2^ADDR_W; boundaries are EXT_BASE + n * span/8.
module xmem_page_sel
    import xmem_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int unsigned EXT_BASE = 32'h1000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LIMIT_W-1:0]  limit,
    input  logic [CODE_W-1:0]   code_lo,
    input  logic [CODE_W-1:0]   code_hi,
    output logic                upper,
    output logic [CODE_W-1:0]   code
);

    localparam int          NSEG     = 1 << LIMIT_W;
    localparam int unsigned EXT_SIZE = (32'd1 << ADDR_W) - EXT_BASE;
    localparam int unsigned STEP     = EXT_SIZE / NSEG;
    localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(EXT_BASE);

    logic [NSEG-1:0] at_or_above;
    logic [ADDR_W:0] addr_x;

    assign addr_x         = {1'b0, addr};
    assign at_or_above[0] = 1'b1;

    // One comparator per possible boundary.
    for (genvar g = 1; g < NSEG; g++) begin : g_bound
        localparam logic [ADDR_W:0] BND = (ADDR_W+1)'(EXT_BASE + g * STEP);
        assign at_or_above[g] = (addr_x >= BND);
    end

    // Page choice and code selection.
    always_comb begin
        upper = (limit == '0) || at_or_above[limit];
        code  = upper ? code_hi : code_lo;
    end

    // R5: an address below the external base never lands in the upper page when split.
    always_comb begin
        if (limit != '0 && addr_x < BASE_X)
            a_r5_below_base_lower: assert (!upper);
    end

endmodule

// File: rtl/xmem_seq.sv
// Access sequencer: latch phase, setup phase, strobe with wait cycles, optional
// recovery, then one completion cycle. Stalls the core until completion.
// Assumes the request and its address stay stable while stall is high and that
// the configuration does not change during an access.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                req_rd,
    input  logic                req_wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [CODE_W-1:0]   code,
    input  logic [DATA_W-1:0]   bus_in,
    output logic                stall,
    output logic [DATA_W-1:0]   rdata,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic [DATA_W-1:0]   bus_out,
    output logic                bus_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);

    xm_state_e          state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               is_wr_q;
    logic               rec_q;
    logic [1:0]         cnt_q;
    logic               req;

    assign req = req_rd | req_wr;

    // Access state machine and captured access parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            is_wr_q <= 1'b0;
            rec_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (en && req) begin
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        is_wr_q <= req_wr;
                        cnt_q   <= wait_extra(code);
                        rec_q   <= wait_recover(code);
                        state_q <= ST_LATCH;
                    end
                end
                ST_LATCH: state_q <= ST_SETUP;
                ST_SETUP: state_q <= ST_STROBE;
                ST_STROBE: begin
                    if (cnt_q == '0) begin
                        if (!is_wr_q) rdata_q <= bus_in;
                        state_q <= rec_q ? ST_RECOVER : ST_DONE;
                    end else begin
                        cnt_q <= cnt_q - 2'd1;
                    end
                end
                ST_RECOVER: state_q <= ST_DONE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Pin-side and core-side outputs decoded from the state.
    always_comb begin
        ale     = (state_q == ST_LATCH);
        rd_n    = !((state_q == ST_STROBE) && !is_wr_q);
        wr_n    = !((state_q == ST_STROBE) && is_wr_q);
        bus_oe  = (state_q == ST_LATCH) ||
                  (is_wr_q && (state_q == ST_SETUP || state_q == ST_STROBE));
        bus_out = (state_q == ST_LATCH) ? addr_q[DATA_W-1:0] : wdata_q;
        addr_hi = addr_q[ADDR_W-1:DATA_W];
        stall   = (state_q == ST_IDLE) ? (en && req) : (state_q != ST_DONE);
        rdata   = rdata_q;
    end

    // R4: the latch pulse lasts exactly one cycle.
    a_r4_latch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4: a strobe begins two cycles after the latch pulse.
    a_r4_strobe_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (rd_n && wr_n) ##1 (!rd_n || !wr_n));

    // R8: the bus is driven whenever the write strobe is low.
    a_r8_bus_driven_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> bus_oe);

    // R9: the bus is released whenever the read strobe is low.
    a_r9_bus_free_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    // R7: stall drops only after a strobe or recovery cycle, never mid-setup.
    a_r7_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ale || (!ale && $past(ale))) |-> stall);

endmodule

// File: rtl/xmem_pin_mux.sv
// Pin ownership: while enabled the interface drives all its pins, ignoring the
// general-purpose directions; while disabled the general-purpose values pass through.
module xmem_pin_mux #(
    parameter int DATA_W = 8,
    parameter int AH_W   = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] bus_out,
    input  logic              bus_oe,
    input  logic [AH_W-1:0]   addr_hi,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] gp_ad_o,
    input  logic [DATA_W-1:0] gp_ad_oe,
    input  logic [AH_W-1:0]   gp_ah_o,
    input  logic [AH_W-1:0]   gp_ah_oe,
    input  logic [2:0]        gp_ctl_o,
    input  logic [2:0]        gp_ctl_oe,
    output logic [DATA_W-1:0] pad_ad_o,
    output logic [DATA_W-1:0] pad_ad_oe,
    output logic [AH_W-1:0]   pad_ah_o,
    output logic [AH_W-1:0]   pad_ah_oe,
    output logic [2:0]        pad_ctl_o,
    output logic [2:0]        pad_ctl_oe
);

    // Select interface or general-purpose drive for every pin group.
    always_comb begin
        if (en) begin
            pad_ad_o   = bus_out;
            pad_ad_oe  = {DATA_W{bus_oe}};
            pad_ah_o   = addr_hi;
            pad_ah_oe  = '1;
            pad_ctl_o  = {wr_n, rd_n, ale};
            pad_ctl_oe = 3'b111;
        end else begin
            pad_ad_o   = gp_ad_o;
            pad_ad_oe  = gp_ad_oe;
            pad_ah_o   = gp_ah_o;
            pad_ah_oe  = gp_ah_oe;
            pad_ctl_o  = gp_ctl_o;
            pad_ctl_oe = gp_ctl_oe;
        end
    end

    // R3: an active strobe is only ever presented on an enabled pin.
    always_comb begin
        if (en && (!rd_n || !wr_n))
            a_r3_strobe_owned: assert (pad_ctl_oe == 3'b111);
    end

endmodule

// File: rtl/xmem_bridge.sv
// Top of the paged wait-state external memory interface.
// Connects the control registers, page decoder, access sequencer and pin mux.
// Assumes the core holds its request stable while stall is high.
module xmem_bridge
    import xmem_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int unsigned EXT_BASE = 32'h1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic                     reg_sel,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_stall,
    input  logic [DATA_W-1:0]        gp_ad_o,
    input  logic [DATA_W-1:0]        gp_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] gp_ah_o,
    input  logic [ADDR_W-DATA_W-1:0] gp_ah_oe,
    input  logic [2:0]               gp_ctl_o,
    input  logic [2:0]               gp_ctl_oe,
    input  logic [DATA_W-1:0]        pad_ad_i,
    output logic [DATA_W-1:0]        pad_ad_o,
    output logic [DATA_W-1:0]        pad_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] pad_ah_o,
    output logic [ADDR_W-DATA_W-1:0] pad_ah_oe,
    output logic [2:0]               pad_ctl_o,
    output logic [2:0]               pad_ctl_oe
);

    localparam int AH_W = ADDR_W - DATA_W;

    logic               en;
    logic [LIMIT_W-1:0] limit;
    logic [CODE_W-1:0]  code_lo;
    logic [CODE_W-1:0]  code_hi;
    logic [CODE_W-1:0]  code_sel;
    logic               page_upper;
    logic               ale;
    logic               rd_n;
    logic               wr_n;
    logic [DATA_W-1:0]  bus_out;
    logic               bus_oe;
    logic [AH_W-1:0]    addr_hi;

    xmem_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .en      (en),
        .limit   (limit),
        .code_lo (code_lo),
        .code_hi (code_hi)
    );

    xmem_page_sel #(
        .ADDR_W   (ADDR_W),
        .EXT_BASE (EXT_BASE)
    ) u_page (
        .addr    (cpu_addr),
        .limit   (limit),
        .code_lo (code_lo),
        .code_hi (code_hi),
        .upper   (page_upper),
        .code    (code_sel)
    );

    xmem_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .req_rd  (cpu_rd),
        .req_wr  (cpu_wr),
        .addr    (cpu_addr),
        .wdata   (cpu_wdata),
        .code    (code_sel),
        .bus_in  (pad_ad_i),
        .stall   (cpu_stall),
        .rdata   (cpu_rdata),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .bus_out (bus_out),
        .bus_oe  (bus_oe),
        .addr_hi (addr_hi)
    );

    xmem_pin_mux #(
        .DATA_W (DATA_W),
        .AH_W   (AH_W)
    ) u_pins (
        .en         (en),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .addr_hi    (addr_hi),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .gp_ad_o    (gp_ad_o),
        .gp_ad_oe   (gp_ad_oe),
        .gp_ah_o    (gp_ah_o),
        .gp_ah_oe   (gp_ah_oe),
        .gp_ctl_o   (gp_ctl_o),
        .gp_ctl_oe  (gp_ctl_oe),
        .pad_ad_o   (pad_ad_o),
        .pad_ad_oe  (pad_ad_oe),
        .pad_ah_o   (pad_ah_o),
        .pad_ah_oe  (pad_ah_oe),
        .pad_ctl_o  (pad_ctl_o),
        .pad_ctl_oe (pad_ctl_oe)
    );

    // R2: with the interface disabled the core is never stalled.
    a_r2_no_stall_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(cpu_stall)) |-> !cpu_stall);

    // R5: with no split every access uses the upper-page code.
    a_r5_no_split_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> (code_sel == code_hi));

endmodule

// File: tb/xmem_bridge_bench.sv
module xmem_bridge_bench;

    localparam int          ADDR_W   = 16;
    localparam int          DATA_W   = 8;
    localparam int unsigned EXT_BASE = 32'h1000;
    localparam int unsigned STEP     = ((32'd1 << ADDR_W) - EXT_BASE) / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall;
    logic [7:0]  gp_ad_o = '0;
    logic [7:0]  gp_ad_oe = '0;
    logic [7:0]  gp_ah_o = '0;
    logic [7:0]  gp_ah_oe = '0;
    logic [2:0]  gp_ctl_o = '0;
    logic [2:0]  gp_ctl_oe = '0;
    logic [7:0]  pad_ad_i;
    logic [7:0]  pad_ad_o;
    logic [7:0]  pad_ad_oe;
    logic [7:0]  pad_ah_o;
    logic [7:0]  pad_ah_oe;
    logic [2:0]  pad_ctl_o;
    logic [2:0]  pad_ctl_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic [15:0] lat_addr = '0;

    always #2.5 clk = ~clk;

    xmem_bridge #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .EXT_BASE (EXT_BASE)
    ) u_xmem_bridge (
        .clk (clk), .rst_n (rst_n),
        .reg_we (reg_we), .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_rd (cpu_rd), .cpu_wr (cpu_wr),
        .cpu_rdata (cpu_rdata), .cpu_stall (cpu_stall),
        .gp_ad_o (gp_ad_o), .gp_ad_oe (gp_ad_oe), .gp_ah_o (gp_ah_o), .gp_ah_oe (gp_ah_oe),
        .gp_ctl_o (gp_ctl_o), .gp_ctl_oe (gp_ctl_oe),
        .pad_ad_i (pad_ad_i), .pad_ad_o (pad_ad_o), .pad_ad_oe (pad_ad_oe),
        .pad_ah_o (pad_ah_o), .pad_ah_oe (pad_ah_oe),
        .pad_ctl_o (pad_ctl_o), .pad_ctl_oe (pad_ctl_oe)
    );

    // External memory model: content is a function of the latched address.
    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign pad_ad_i = mem_val(lat_addr);

    always @(negedge clk) begin
        if (pad_ctl_oe[0] && pad_ctl_o[0]) lat_addr <= {pad_ah_o, pad_ad_o};
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input bit sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic configure(input bit en, input logic [2:0] lim,
                             input logic [1:0] lo, input logic [1:0] hi);
        reg_write(1'b0, {6'b0, hi[1], en});
        reg_write(1'b1, {2'b0, hi[0], lo, lim});
    endtask

    // One access with per-cycle checks of latch, strobe and bus behaviour.
    task automatic do_access(input logic [15:0] a, input bit wr,
                             input logic [7:0] wd, input logic [1:0] code);
        int e, rec, idx, ale_err, stb_err, bus_err, stb_cnt;
        bit exp_ale, exp_stb, exp_oe, stb_lo;
        e   = (code == 2'd0) ? 0 : (code == 2'd1) ? 1 : 2;
        rec = (code == 2'd3) ? 1 : 0;
        idx = 0; ale_err = 0; stb_err = 0; bus_err = 0; stb_cnt = 0;
        cpu_addr = a; cpu_wdata = wd; cpu_rd = !wr; cpu_wr = wr;
        while (1) begin
            #1;
            exp_ale = (idx == 1);
            exp_stb = (idx >= 3) && (idx <= 3 + e);
            exp_oe  = (idx == 1) || (wr && idx >= 2 && idx <= 3 + e);
            stb_lo  = wr ? !pad_ctl_o[2] : !pad_ctl_o[1];
            if (pad_ctl_o[0] != exp_ale) ale_err++;
            if (exp_ale && (pad_ad_o != a[7:0] || pad_ah_o != a[15:8])) ale_err++;
            if (stb_lo != exp_stb || (wr ? !pad_ctl_o[1] : !pad_ctl_o[2])) stb_err++;
            if (stb_lo) stb_cnt++;
            if (pad_ad_oe != (exp_oe ? 8'hFF : 8'h00)) bus_err++;
            if (exp_oe && idx >= 2 && pad_ad_o != wd) bus_err++;
            if (!cpu_stall || idx > 20) break;
            idx++;
            @(negedge clk);
        end
        check(ale_err == 0, "R4 latch/setup phase", ale_err, 0);
        check(stb_err == 0 && stb_cnt == 1 + e, "R6 strobe length", stb_cnt, 1 + e);
        check(idx == 4 + e + rec, "R7 stalled cycles", idx, 4 + e + rec);
        check(bus_err == 0, wr ? "R8 write bus window" : "R9 read bus released", bus_err, 0);
        if (!wr) check(cpu_rdata == mem_val(a), "R9 read data", cpu_rdata, mem_val(a));
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [1:0] lo_tab [4];
        logic [1:0] hi_tab [4];
        logic [15:0] pts [4];
        lo_tab = '{2'd0, 2'd2, 2'd3, 2'd1};
        hi_tab = '{2'd3, 2'd1, 2'd0, 2'd2};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of both registers
        reg_sel = 1'b0; #1;
        check(reg_rdata == 8'h00, "R1 reset reg0", reg_rdata, 0);
        reg_sel = 1'b1; #1;
        check(reg_rdata == 8'h00, "R1 reset reg1", reg_rdata, 0);
        @(negedge clk);

        // R2 disabled: pins pass through, request ignored
        gp_ad_o = 8'hA5; gp_ad_oe = 8'h3C; gp_ah_o = 8'h96; gp_ah_oe = 8'hF0;
        gp_ctl_o = 3'b010; gp_ctl_oe = 3'b101;
        cpu_addr = 16'h2345; cpu_rd = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            check(!cpu_stall, "R2 no stall when disabled", cpu_stall, 0);
            check(pad_ad_o == 8'hA5 && pad_ad_oe == 8'h3C && pad_ah_o == 8'h96 &&
                  pad_ah_oe == 8'hF0 && pad_ctl_o == 3'b010 && pad_ctl_oe == 3'b101,
                  "R2 pins follow general-purpose", {pad_ad_oe, pad_ah_oe}, 16'h3CF0);
            @(negedge clk);
        end
        cpu_rd = 1'b0;

        // R1 read-back of writable bits only
        reg_write(1'b0, 8'hFF); reg_write(1'b1, 8'hFF);
        reg_sel = 1'b0; #1;
        check(reg_rdata == 8'h03, "R1 reg0 readback", reg_rdata, 8'h03);
        reg_sel = 1'b1; #1;
        check(reg_rdata == 8'h3F, "R1 reg1 readback", reg_rdata, 8'h3F);
        @(negedge clk);

        // R3 enabled idle owns pins even with all directions cleared
        gp_ad_oe = '0; gp_ah_oe = '0; gp_ctl_oe = '0;
        configure(1'b1, 3'd0, 2'd0, 2'd0);
        #1;
        check(pad_ah_oe == 8'hFF && pad_ctl_oe == 3'b111 && pad_ctl_o == 3'b110,
              "R3 pin ownership idle", {pad_ah_oe, 5'b0, pad_ctl_o}, 16'hFF06);
        check(pad_ad_oe == 8'h00, "R8 bus released when idle", pad_ad_oe, 0);
        @(negedge clk);

        // R10 each half of the upper code takes effect independently
        configure(1'b1, 3'd0, 2'd0, 2'd2);
        do_access(16'h4000, 1'b0, 8'h00, 2'd2);
        configure(1'b1, 3'd0, 2'd0, 2'd1);
        do_access(16'h4001, 1'b0, 8'h00, 2'd1);
        check(1'b1, "R10 split upper code exercised", 0, 0);

        // R5/R6/R7/R8/R9 sweep over limits, code pairs, boundary addresses, directions
        for (int lim = 0; lim < 8; lim++) begin
            for (int p = 0; p < 4; p++) begin
                int unsigned bnd;
                bnd = EXT_BASE + lim * STEP;
                configure(1'b1, 3'(lim), lo_tab[p], hi_tab[p]);
                pts[0] = 16'(EXT_BASE);
                pts[1] = 16'(bnd - 1);
                pts[2] = 16'(bnd);
                pts[3] = 16'hFFFF;
                for (int k = 0; k < 4; k++) begin
                    for (int d = 0; d < 2; d++) begin
                        bit up;
                        up = (lim == 0) || (32'(pts[k]) >= bnd);
                        do_access(pts[k], d[0], 8'(pts[k] + 16'(lim * 7 + p)),
                                  up ? hi_tab[p] : lo_tab[p]);
                    end
                end
            end
        end

        // R9 read data held across a later write
        configure(1'b1, 3'd0, 2'd0, 2'd0);
        do_access(16'h7777, 1'b0, 8'h00, 2'd0);
        do_access(16'h8888, 1'b1, 8'hC3, 2'd0);
        check(cpu_rdata == mem_val(16'h7777), "R9 read data held", cpu_rdata, mem_val(16'h7777));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule